// File: doc/BRIEF.md
# Bidirectional Serial Audio Port

This block is a stereo serial audio port with one line of data and three clock lines that work in one direction at a time. When the direction control is set, the port is clock master and transmitter. It divides its system clock into a master clock at 512 times the sample rate, a bit clock at 64 times the sample rate and a word clock at the sample rate. It drives all three clocks out together with the serial data, and it raises drive enables so that the pads outside the block turn the lines into outputs. Each frame holds a left slot and a right slot of 32 bit clocks each. A 24-bit sample is sent in each slot, most significant bit first.

When the direction control is clear, the drive enables drop and the port becomes a slave receiver. The incoming bit clock, word clock and data are synchronised to the system clock. Word-clock changes mark the slot boundaries. A left and right sample pair is presented in parallel with a one-cycle valid strobe. A separate alignment control selects between two positions of the 24-bit word: standard, where the word starts one bit clock after the word-clock change, and non-standard, where it starts on that change. Any change of direction restarts the port cleanly.

Top module: `audio_serial_port`

## Requirements
- R1: With `dirOut` = 1 both drive enables are high. With `dirOut` = 0 both are low and `mclkOut`, `bclkOut`, `wclkOut` and `sdOut` are all held at 0. The enables and lines follow `dirOut` after one clock.
- R2: In output mode `mclkOut` has a period of 2 system clocks, `bclkOut` a period of 16 system clocks (8 master clocks), and a frame lasts 64 bit clocks, so 8 master clock rising edges fall between successive bit clock rising edges.
- R3: In output mode `wclkOut` is 0 during the left slot and 1 during the right slot (32 bit clocks each). It changes only in the cycle where `bclkOut` falls.
- R4: In output mode each slot carries the 24-bit sample most significant bit first. `sdOut` changes only when `bclkOut` falls. Every bit position of a slot that does not hold a sample bit is 0.
- R5: With `altAlign` = 0 (standard) the sample MSB is in slot bit position 1, counted from 0 at the first bit clock rising edge after the word-clock change. With `altAlign` = 1 (non-standard) the MSB is in position 0.
- R6: `txLeft` and `txRight` are both captured at the start of each left slot. A change made later in that frame affects only the next frame, including its right slot.
- R7: When `dirOut` goes from 0 to 1, the first frame starts at a full left-slot boundary. The first 32 bit clocks carry `wclkOut` = 0 and the complete left sample.
- R8: In input mode the port captures 24 bits per slot at the bit positions given in R5, sampling `sdIn` on rising `bclkIn`. After the last data bit of a right slot whose preceding left slot was captured, it presents `rxLeft`/`rxRight` with `rxValid` high for exactly one cycle.
- R9: While `dirOut` = 1, activity on `bclkIn`, `wclkIn` and `sdIn` produces no `rxValid` and leaves `rxLeft`/`rxRight` unchanged.
- R10: A change of `dirOut` discards any half-received pair. A right slot received after the change produces no `rxValid` until a new left slot has been captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the master clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| dirOut | input | 1 | 1 = master transmitter, 0 = slave receiver |
| altAlign | input | 1 | 0 = standard alignment, 1 = non-standard alignment |
| txLeft | input | 24 | Left sample to transmit |
| txRight | input | 24 | Right sample to transmit |
| mclkOut | output | 1 | Master clock at 512 times the sample rate |
| bclkOut | output | 1 | Bit clock at 64 times the sample rate |
| wclkOut | output | 1 | Word clock, 0 = left slot, 1 = right slot |
| sdOut | output | 1 | Serial data out |
| clkDriveEn | output | 1 | Drive enable for the three clock pads |
| dataDriveEn | output | 1 | Drive enable for the data pad |
| bclkIn | input | 1 | External bit clock in receive mode |
| wclkIn | input | 1 | External word clock in receive mode |
| sdIn | input | 1 | Serial data in |
| rxLeft | output | 24 | Last received left sample |
| rxRight | output | 24 | Last received right sample |
| rxValid | output | 1 | One-cycle strobe: new sample pair |

## Verification
A change of direction and the completion of a right slot in receive mode can fall in the same cycle. In that case the direction change has to win, so no valid strobe may appear. The bench provokes this by flipping the direction control briefly while the right slot of a frame is still arriving. It then finishes that slot and requires that no pair is reported, and it requires that the next full frame is reported with the right data. In transmit mode, latching a new sample pair coincides with the bit-clock falling edge and the word-clock change at the left boundary. The bench checks this by changing the inputs in the middle of a frame and decoding two frames in a row.

// File: rtl/audio_port_pkg.sv
package audio_port_pkg;

  // Strobes from the control module to the datapath, valid for one cycle.
  typedef struct packed {
    logic dirReset;     // direction changed: clear shifters and strobe
    logic txLoadLeft;   // start of left slot: load left, capture right
    logic txLoadRight;  // start of right slot: load held right sample
    logic txShift;      // start of any other bit: advance shifter
    logic rxShiftEn;    // received bit lies inside the sample word
    logic rxStoreLeft;  // last bit of a left word
    logic rxStorePair;  // last bit of a right word with a left word held
  } portStrobes_t;

endpackage

// File: rtl/audio_port_sync.sv
module audio_port_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/audio_port_ctrl.sv
module audio_port_ctrl
  import audio_port_pkg::*;
#(
  parameter int MCLK_DIV_LOG2  = 1,
  parameter int BCLK_DIV_LOG2  = 3,
  parameter int SLOT_BITS_LOG2 = 5,
  parameter int SAMPLE_W       = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dirOut,
  input  logic         altAlign,
  input  logic         bclkS,
  input  logic         wclkS,
  output logic         dirActive,
  output logic         mclkQ,
  output logic         bclkQ,
  output logic         wclkQ,
  output portStrobes_t strobes
);

  localparam int BIT_LOG2 = MCLK_DIV_LOG2 + BCLK_DIV_LOG2;
  localparam int CNT_W    = BIT_LOG2 + SLOT_BITS_LOG2 + 1;
  localparam int POS_W    = SLOT_BITS_LOG2 + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic                      dirQ;
  logic [CNT_W-1:0]          cnt;
  logic                      dirChange;
  logic                      txRun;
  logic                      rxRun;
  logic                      bitStart;
  logic [SLOT_BITS_LOG2-1:0] slotPos;

  assign dirChange = (dirOut != dirQ);
  assign txRun     = dirQ && !dirChange;
  assign rxRun     = !dirQ && !dirChange;
  assign bitStart  = (cnt[BIT_LOG2-1:0] == '0);
  assign slotPos   = cnt[CNT_W-2:BIT_LOG2];
  assign dirActive = dirQ;

  // Transmit timing: one free-running counter covers a whole frame.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ  <= 1'b0;
      cnt   <= '0;
      mclkQ <= 1'b0;
      bclkQ <= 1'b0;
      wclkQ <= 1'b0;
    end else if (dirChange) begin
      dirQ  <= dirOut;
      cnt   <= '0;
      mclkQ <= 1'b0;
      bclkQ <= 1'b0;
      wclkQ <= 1'b0;
    end else if (dirQ) begin
      cnt   <= cnt + CNT_W'(1);
      mclkQ <= cnt[MCLK_DIV_LOG2-1];
      bclkQ <= cnt[BIT_LOG2-1];
      wclkQ <= cnt[CNT_W-1];
    end else begin
      cnt   <= '0;
      mclkQ <= 1'b0;
      bclkQ <= 1'b0;
      wclkQ <= 1'b0;
    end
  end

  // Receive framing.
  logic             bclkPrevQ;
  logic             wclkPrevQ;
  logic [POS_W-1:0] posQ;
  logic             leftSeenQ;
  logic             bclkRise;
  logic             newSlot;
  logic [POS_W-1:0] posNext;
  logic [POS_W-1:0] firstPos;
  logic [POS_W-1:0] lastPos;
  logic             inData;
  logic             lastBit;

  always_comb begin
    bclkRise = bclkS && !bclkPrevQ;
    newSlot  = (wclkS != wclkPrevQ);
    if (newSlot)              posNext = '0;
    else if (posQ == POS_MAX) posNext = posQ;
    else                      posNext = posQ + POS_W'(1);
    firstPos = altAlign ? '0 : POS_W'(1);
    lastPos  = firstPos + POS_W'(SAMPLE_W - 1);
    inData   = (posNext >= firstPos) && (posNext <= lastPos);
    lastBit  = (posNext == lastPos);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkPrevQ <= 1'b0;
      wclkPrevQ <= 1'b1;
      posQ      <= '0;
      leftSeenQ <= 1'b0;
    end else begin
      bclkPrevQ <= bclkS;
      if (!rxRun) begin
        wclkPrevQ <= 1'b1;
        posQ      <= '0;
        leftSeenQ <= 1'b0;
      end else if (bclkRise) begin
        wclkPrevQ <= wclkS;
        posQ      <= posNext;
        if (lastBit && !wclkS)      leftSeenQ <= 1'b1;
        else if (lastBit && wclkS)  leftSeenQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.dirReset    = dirChange;
    strobes.txLoadLeft  = txRun && bitStart && (slotPos == '0) && !cnt[CNT_W-1];
    strobes.txLoadRight = txRun && bitStart && (slotPos == '0) && cnt[CNT_W-1];
    strobes.txShift     = txRun && bitStart && (slotPos != '0);
    strobes.rxShiftEn   = rxRun && bclkRise && inData;
    strobes.rxStoreLeft = rxRun && bclkRise && lastBit && !wclkS;
    strobes.rxStorePair = rxRun && bclkRise && lastBit && wclkS && leftSeenQ;
  end

endmodule

// File: rtl/audio_port_dp.sv
module audio_port_dp
  import audio_port_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                altAlign,
  input  logic                dirActive,
  input  portStrobes_t        strobes,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  input  logic                sdS,
  output logic                sdOut,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  localparam int PAD_W = SLOT_BITS - SAMPLE_W;

  function automatic logic [SLOT_BITS-1:0] alignSample(
    input logic [SAMPLE_W-1:0] s,
    input logic                alt
  );
    logic [SLOT_BITS-1:0] w;
    w = {s, {PAD_W{1'b0}}};
    return alt ? w : (w >> 1);
  endfunction

  logic [SLOT_BITS-1:0] txShifter;
  logic [SAMPLE_W-1:0]  holdRight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShifter <= '0;
      holdRight <= '0;
    end else if (strobes.dirReset) begin
      txShifter <= '0;
    end else if (strobes.txLoadLeft) begin
      txShifter <= alignSample(txLeft, altAlign);
      holdRight <= txRight;
    end else if (strobes.txLoadRight) begin
      txShifter <= alignSample(holdRight, altAlign);
    end else if (strobes.txShift) begin
      txShifter <= {txShifter[SLOT_BITS-2:0], 1'b0};
    end
  end

  assign sdOut = dirActive && txShifter[SLOT_BITS-1];

  logic [SAMPLE_W-1:0] rxShift;
  logic [SAMPLE_W-1:0] rxShiftNext;
  logic [SAMPLE_W-1:0] leftHeld;

  assign rxShiftNext = {rxShift[SAMPLE_W-2:0], sdS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      leftHeld <= '0;
      rxLeft   <= '0;
      rxRight  <= '0;
      rxValid  <= 1'b0;
    end else if (strobes.dirReset) begin
      rxShift  <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= strobes.rxStorePair;
      if (strobes.rxShiftEn)   rxShift  <= rxShiftNext;
      if (strobes.rxStoreLeft) leftHeld <= rxShiftNext;
      if (strobes.rxStorePair) begin
        rxLeft  <= leftHeld;
        rxRight <= rxShiftNext;
      end
    end
  end

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import audio_port_pkg::*;
#(
  parameter int MCLK_DIV_LOG2  = 1,
  parameter int BCLK_DIV_LOG2  = 3,
  parameter int SLOT_BITS_LOG2 = 5,
  parameter int SAMPLE_W       = 24,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                dirOut,
  input  logic                altAlign,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                mclkOut,
  output logic                bclkOut,
  output logic                wclkOut,
  output logic                sdOut,
  output logic                clkDriveEn,
  output logic                dataDriveEn,
  input  logic                bclkIn,
  input  logic                wclkIn,
  input  logic                sdIn,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  localparam int SLOT_BITS = 1 << SLOT_BITS_LOG2;

  logic         bclkS;
  logic         wclkS;
  logic         sdS;
  logic         dirActive;
  portStrobes_t strobes;

  audio_port_sync #(
    .WIDTH (3),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({bclkIn, wclkIn, sdIn}),
    .syncOut({bclkS, wclkS, sdS})
  );

  audio_port_ctrl #(
    .MCLK_DIV_LOG2 (MCLK_DIV_LOG2),
    .BCLK_DIV_LOG2 (BCLK_DIV_LOG2),
    .SLOT_BITS_LOG2(SLOT_BITS_LOG2),
    .SAMPLE_W      (SAMPLE_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dirOut   (dirOut),
    .altAlign (altAlign),
    .bclkS    (bclkS),
    .wclkS    (wclkS),
    .dirActive(dirActive),
    .mclkQ    (mclkOut),
    .bclkQ    (bclkOut),
    .wclkQ    (wclkOut),
    .strobes  (strobes)
  );

  audio_port_dp #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_BITS(SLOT_BITS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .altAlign (altAlign),
    .dirActive(dirActive),
    .strobes  (strobes),
    .txLeft   (txLeft),
    .txRight  (txRight),
    .sdS      (sdS),
    .sdOut    (sdOut),
    .rxLeft   (rxLeft),
    .rxRight  (rxRight),
    .rxValid  (rxValid)
  );

  assign clkDriveEn  = dirActive;
  assign dataDriveEn = dirActive;

endmodule

// File: rtl/audio_port_checker.sv
module audio_port_checker (
  input logic clk,
  input logic rstN,
  input logic dirOut,
  input logic clkDriveEn,
  input logic dataDriveEn,
  input logic mclkOut,
  input logic bclkOut,
  input logic wclkOut,
  input logic sdOut,
  input logic rxValid
);

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rstN)
    !clkDriveEn |-> (!mclkOut && !bclkOut && !wclkOut && !sdOut));

  assert_wclk_on_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkDriveEn && $past(clkDriveEn) && (wclkOut != $past(wclkOut))) |-> $fell(bclkOut));

  assert_sd_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataDriveEn && $past(dataDriveEn) && $past(dataDriveEn, 2) && (sdOut != $past(sdOut)))
      |-> $fell(bclkOut));

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_no_rx_when_driving_R9: assert property (@(posedge clk) disable iff (!rstN)
    clkDriveEn |-> !rxValid);

  assert_dir_flip_cancels_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dirOut != $past(dirOut)) |=> !rxValid);

endmodule

bind audio_serial_port audio_port_checker u_portChecker (
  .clk        (clk),
  .rstN       (rstN),
  .dirOut     (dirOut),
  .clkDriveEn (clkDriveEn),
  .dataDriveEn(dataDriveEn),
  .mclkOut    (mclkOut),
  .bclkOut    (bclkOut),
  .wclkOut    (wclkOut),
  .sdOut      (sdOut),
  .rxValid    (rxValid)
);

// File: tb/audio_serial_port_bench.sv
`timescale 1ns/1ps
module audio_serial_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        dirOut = 1'b0;
  logic        altAlign = 1'b0;
  logic [23:0] txLeft = '0;
  logic [23:0] txRight = '0;
  logic        bclkIn = 1'b0;
  logic        wclkIn = 1'b0;
  logic        sdIn = 1'b0;
  logic        mclkOut, bclkOut, wclkOut, sdOut, clkDriveEn, dataDriveEn;
  logic [23:0] rxLeft, rxRight;
  logic        rxValid;

  int checks = 0;
  int failures = 0;
  int validCount = 0;
  logic [23:0] gotL = '0;
  logic [23:0] gotR = '0;
  int idleViol = 0;
  logic prevDir = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_serial_port u_audio_serial_port (
    .clk(clk), .rstN(rstN), .dirOut(dirOut), .altAlign(altAlign),
    .txLeft(txLeft), .txRight(txRight),
    .mclkOut(mclkOut), .bclkOut(bclkOut), .wclkOut(wclkOut), .sdOut(sdOut),
    .clkDriveEn(clkDriveEn), .dataDriveEn(dataDriveEn),
    .bclkIn(bclkIn), .wclkIn(wclkIn), .sdIn(sdIn),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );

  always @(negedge clk) begin
    if (rstN && rxValid) begin
      validCount++;
      gotL = rxLeft;
      gotR = rxRight;
    end
    if (rstN && !dirOut && !prevDir &&
        (clkDriveEn || dataDriveEn || mclkOut || bclkOut || wclkOut || sdOut))
      idleViol++;
    prevDir = dirOut;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic expBit(input bit alt, input logic [23:0] s, input int p);
    if (alt) return (p < 24) ? s[23 - p] : 1'b0;
    return (p >= 1 && p <= 24) ? s[24 - p] : 1'b0;
  endfunction

  function automatic logic [63:0] expFrame(input bit alt, input logic [23:0] l,
                                           input logic [23:0] r);
    logic [63:0] f;
    for (int k = 0; k < 64; k++) f[k] = expBit(alt, (k < 32) ? l : r, k % 32);
    return f;
  endfunction

  task automatic recvFrame(output logic [63:0] bits, output logic [63:0] wcl,
                           output int badPeriod, output int mclkRises);
    int rises = 0;
    int lastT = -1;
    int t = 0;
    logic pb = bclkOut;
    logic pm = mclkOut;
    bits = '0; wcl = '0; badPeriod = 0; mclkRises = 0;
    while (rises < 64 && t < 3000) begin
      @(negedge clk);
      t++;
      if (rises > 0 && mclkOut && !pm) mclkRises++;
      if (bclkOut && !pb) begin
        bits[rises] = sdOut;
        wcl[rises] = wclkOut;
        if (lastT >= 0 && t - lastT != 16) badPeriod++;
        lastT = t;
        rises++;
      end
      pb = bclkOut;
      pm = mclkOut;
    end
    if (rises < 64) badPeriod += 1000;
  endtask

  task automatic sendFrame(input bit alt, input logic [23:0] l, input logic [23:0] r,
                           input int flipAt);
    for (int k = 0; k < 64; k++) begin
      wclkIn = (k >= 32);
      sdIn = expBit(alt, (k < 32) ? l : r, k % 32);
      bclkIn = 1'b0;
      if (k == flipAt) begin
        @(negedge clk); dirOut = 1'b1;
        repeat (3) @(negedge clk);
        dirOut = 1'b0;
        repeat (4) @(negedge clk);
      end else begin
        repeat (8) @(negedge clk);
      end
      bclkIn = 1'b1;
      repeat (8) @(negedge clk);
    end
    bclkIn = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!clkDriveEn && !dataDriveEn, "R1", "drive enables after reset",
          {clkDriveEn, dataDriveEn}, 0);
    check({mclkOut, bclkOut, wclkOut, sdOut} == 0, "R1", "lines after reset",
          {mclkOut, bclkOut, wclkOut, sdOut}, 0);
    check(!rxValid && rxLeft == 0 && rxRight == 0, "R8", "receive outputs after reset",
          {rxValid, rxLeft, rxRight}, 0);
  endtask

  task automatic testOutput(input bit alt, input logic [23:0] l, input logic [23:0] r);
    logic [63:0] bits, wcl;
    int bad, mr;
    string alignReq = alt ? "R5" : "R4";
    dirOut = 1'b0;
    repeat (4) @(negedge clk);
    altAlign = alt; txLeft = l; txRight = r;
    @(negedge clk); dirOut = 1'b1;
    recvFrame(bits, wcl, bad, mr);
    check(clkDriveEn && dataDriveEn, "R1", "drive enables in output mode",
          {clkDriveEn, dataDriveEn}, 2'b11);
    check(wcl == {32'hFFFF_FFFF, 32'h0}, "R7", "first frame word clock", wcl,
          {32'hFFFF_FFFF, 32'h0});
    check(bits == expFrame(alt, l, r), alignReq, "first frame bits", bits,
          expFrame(alt, l, r));
    check(bad == 0, "R2", "bit clock period errors", bad, 0);
    check(mr == 504, "R2", "master clock rises over 63 bit clocks", mr, 504);
    recvFrame(bits, wcl, bad, mr);
    check(wcl == {32'hFFFF_FFFF, 32'h0}, "R3", "second frame word clock", wcl,
          {32'hFFFF_FFFF, 32'h0});
    check(bits == expFrame(alt, l, r), alignReq, "second frame bits", bits,
          expFrame(alt, l, r));
    dirOut = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testLatch();
    logic [63:0] b0, w0, b1, w1;
    int bad0, m0, bad1, m1;
    altAlign = 1'b0; txLeft = 24'h123456; txRight = 24'hABCDEF;
    @(negedge clk); dirOut = 1'b1;
    fork
      recvFrame(b0, w0, bad0, m0);
      begin
        repeat (100) @(negedge clk);
        txLeft = 24'h0F0F0F; txRight = 24'hC3C3C3;
      end
    join
    recvFrame(b1, w1, bad1, m1);
    check(b0 == expFrame(0, 24'h123456, 24'hABCDEF), "R6", "frame with late change",
          b0, expFrame(0, 24'h123456, 24'hABCDEF));
    check(b1 == expFrame(0, 24'h0F0F0F, 24'hC3C3C3), "R6", "following frame",
          b1, expFrame(0, 24'h0F0F0F, 24'hC3C3C3));
    dirOut = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testInput(input bit alt, input logic [23:0] l, input logic [23:0] r);
    int v0;
    dirOut = 1'b0; altAlign = alt;
    repeat (6) @(negedge clk);
    v0 = validCount;
    sendFrame(alt, l, r, -1);
    check(validCount == v0 + 1, "R8", "valid pulses per frame", validCount - v0, 1);
    check(gotL == l, "R8", "received left", gotL, l);
    check(gotR == r, "R8", "received right", gotR, r);
  endtask

  task automatic testRxIgnored();
    int v0;
    logic [23:0] l0, r0;
    altAlign = 1'b0;
    @(negedge clk); dirOut = 1'b1;
    repeat (6) @(negedge clk);
    v0 = validCount; l0 = rxLeft; r0 = rxRight;
    sendFrame(0, 24'h5A5A5A, 24'hA5A5A5, -1);
    check(validCount == v0, "R9", "valid pulses in output mode", validCount - v0, 0);
    check(rxLeft == l0 && rxRight == r0, "R9", "receive outputs in output mode",
          {rxLeft, rxRight}, {l0, r0});
    dirOut = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic testDirCancel();
    int v0;
    dirOut = 1'b0; altAlign = 1'b0;
    repeat (6) @(negedge clk);
    v0 = validCount;
    sendFrame(0, 24'h111111, 24'h222222, 40);
    check(validCount == v0, "R10", "valid after flip in right slot", validCount - v0, 0);
    sendFrame(0, 24'h654321, 24'h0ABCDE, -1);
    check(validCount == v0 + 1 && gotL == 24'h654321 && gotR == 24'h0ABCDE, "R10",
          "pair after flip recovery", {gotL, gotR}, {24'h654321, 24'h0ABCDE});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testOutput(0, 24'hC0FFEE, 24'h8000A1);
    testOutput(1, 24'h9ABCDE, 24'h000001);
    testLatch();
    testInput(0, 24'hDEAD01, 24'h7BEEF2);
    testInput(1, 24'h800001, 24'h3C5AA5);
    testRxIgnored();
    testDirCancel();
    check(idleViol == 0, "R1", "lines driven while receiving", idleViol, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule